// File: doc/BRIEF.md
# Per-Row Activation Throttle

This block sits between a memory controller's scheduler and its command issue path and decides, for each row activation the scheduler wants to send, whether it may go now or has to wait. It protects neighbouring rows from charge disturbance by slowing down one row that is opened over and over. Rows that differ from each other are never held back against one another.

Two limits apply to each row. Successive activations of one row (same bank, same row address) must be spaced by a minimum time. The number of activations of that row inside one refresh window is capped. Both times are given in nanoseconds and turned into cycle counts from a clock-period parameter. The default cap is the window length divided by the minimum spacing. The block does not keep a counter for every row of the device. A small table follows the most recently activated rows. A row that is not in the table takes the entry that was granted least recently.

The scheduler presents one request at a time and keeps it, unchanged, until it is granted. The block never drops a request, so requests are granted in the order they were presented. Grant is combinational from the request and the table state, and the activation counts as issued at the clock edge that ends the grant cycle.

Top module: `rowthr_gate`

## Requirements
- R1: While reset is asserted, and afterwards with no request presented, both `actGrant` and `actStall` are 0. After reset, a request for any row is granted in the first cycle it is presented.
- R2: If a row was granted at clock edge e, a request for the same bank and row is not granted before edge e+GAP_CYC, where GAP_CYC = MIN_GAP_NS*1000/CLK_PS. If nothing else blocks it, the request is granted exactly at that edge.
- R3: Within one refresh window, a tracked row is granted at most ACT_CAP times. Further requests for it stall.
- R4: The refresh window is WIN_CYC = WINDOW_NS*1000/CLK_PS cycles. All activation counts clear at edges WIN_CYC, 2*WIN_CYC, ... (edges counted from the first edge after reset release). A row stalled only by the cap is granted at the edge after that boundary.
- R5: A request for a row that differs from recently granted rows in row address or in bank is granted at once, whatever the limits of the other rows.
- R6: When a request cannot be granted, `actStall` is 1 and `actGrant` is 0 for every cycle until the grant. `actStall` is 1 only while a request is present. `actGrant` is 1 only while a request is present.
- R7: The table holds ENTRIES rows. A request that misses the table replaces the least recently granted entry. A row evicted this way loses its limits and is granted at once when requested again, while rows still in the table keep theirs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| actValid | input | 1 | Activation request present; held until granted |
| actBank | input | BANK_W | Bank of the requested row |
| actRow | input | ROW_W | Row address of the request |
| actGrant | output | 1 | Request may issue; counts as issued at this clock edge |
| actStall | output | 1 | Request present but held back |

## Verification
A wrong spacing timer shows up on the very next request for the same row: the grant edge moves away from the previous grant plus GAP_CYC. A wrong count or a missed window clear shows up as a capped row that is granted inside its window, or that is still stalled one edge after the boundary. A fault in the replacement order shows up within a single request after the table overflows: an evicted row stalls, or a row that is still tracked is granted without waiting. Each of these errors is visible at the ports in the cycle of the affected request.

// File: rtl/rowthr_pkg.sv
package rowthr_pkg;
  // Update strobes from the decision logic to the row table.
  typedef struct packed {
    logic touch;   // grant to a row already tracked
    logic alloc;   // grant to a new row: take the LRU entry
    logic clear;   // refresh-window boundary: clear all counts
  } rowthr_strb_t;
endpackage

// File: rtl/rowthr_table.sv
module rowthr_table
  import rowthr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int GAP_CYC = 100,
  parameter int ACT_CAP = 128000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  rowthr_strb_t      strb,
  output logic              hit,
  output logic              hitReady
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ACT_CAP + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] CAP_V    = CNT_W'(ACT_CAP);
  localparam logic [IDX_W-1:0] OLDEST   = IDX_W'(ENTRIES - 1);

  logic              valid  [ENTRIES];
  logic [BANK_W-1:0] bankQ  [ENTRIES];
  logic [ROW_W-1:0]  rowQ   [ENTRIES];
  logic [GAP_W-1:0]  gapQ   [ENTRIES];
  logic [CNT_W-1:0]  cntQ   [ENTRIES];
  logic [IDX_W-1:0]  rankQ  [ENTRIES];

  logic [IDX_W-1:0]  hitIdx, victimIdx, selIdx, selRank;
  logic [ENTRIES-1:0] hitVec, victimVec;

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitVec[i]    = valid[i] && (bankQ[i] == reqBank) && (rowQ[i] == reqRow);
      victimVec[i] = (rankQ[i] == OLDEST);
      if (hitVec[i])    hitIdx    = IDX_W'(i);
      if (victimVec[i]) victimIdx = IDX_W'(i);
    end
    hit      = |hitVec;
    hitReady = hit && (gapQ[hitIdx] == '0) && (cntQ[hitIdx] < CAP_V);
    selIdx   = strb.touch ? hitIdx : victimIdx;
    selRank  = rankQ[selIdx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid[i] <= 1'b0;
        bankQ[i] <= '0;
        rowQ[i]  <= '0;
        gapQ[i]  <= '0;
        cntQ[i]  <= '0;
        rankQ[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.alloc && (victimIdx == IDX_W'(i))) begin
          valid[i] <= 1'b1;
          bankQ[i] <= reqBank;
          rowQ[i]  <= reqRow;
          gapQ[i]  <= GAP_LOAD;
          cntQ[i]  <= CNT_W'(1);
        end else if (strb.touch && (hitIdx == IDX_W'(i))) begin
          gapQ[i]  <= GAP_LOAD;
          cntQ[i]  <= strb.clear ? CNT_W'(1) : cntQ[i] + CNT_W'(1);
        end else begin
          if (gapQ[i] != '0) gapQ[i] <= gapQ[i] - GAP_W'(1);
          if (strb.clear)    cntQ[i] <= '0;
        end
        if (strb.touch || strb.alloc) begin
          if (selIdx == IDX_W'(i))     rankQ[i] <= '0;
          else if (rankQ[i] < selRank) rankQ[i] <= rankQ[i] + IDX_W'(1);
        end
      end
    end
  end

  // Assertions
  p_one_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.touch, strb.alloc}));

  p_single_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victimVec) == 1);

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    p_spacing_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.touch && hitVec[g]) |-> (gapQ[g] == '0));
    p_cap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cntQ[g] <= CAP_V);
    p_window_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clear |=> (cntQ[g] <= CNT_W'(1)));
  end
endmodule

// File: rtl/rowthr_ctrl.sv
module rowthr_ctrl
  import rowthr_pkg::*;
#(
  parameter int WIN_CYC = 12800000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         actValid,
  input  logic         hit,
  input  logic         hitReady,
  output rowthr_strb_t strb,
  output logic         actGrant,
  output logic         actStall
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] winCnt;
  logic             winEnd;

  assign winEnd = (winCnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      winCnt <= '0;
    else if (winEnd) winCnt <= '0;
    else             winCnt <= winCnt + WIN_W'(1);
  end

  always_comb begin
    actGrant   = actValid && (!hit || hitReady);
    actStall   = actValid && !actGrant;
    strb.touch = actGrant && hit;
    strb.alloc = actGrant && !hit;
    strb.clear = winEnd;
  end

  p_window_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (winCnt == '0));

  p_grant_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !actValid |-> (!actGrant && !actStall));
endmodule

// File: rtl/rowthr_gate.sv
module rowthr_gate
  import rowthr_pkg::*;
#(
  parameter int CLK_PS     = 5000,
  parameter int MIN_GAP_NS = 500,
  parameter int WINDOW_NS  = 64000000,
  parameter int ACT_CAP    = WINDOW_NS / MIN_GAP_NS,
  parameter int ENTRIES    = 8,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              actValid,
  input  logic [BANK_W-1:0] actBank,
  input  logic [ROW_W-1:0]  actRow,
  output logic              actGrant,
  output logic              actStall
);
  localparam longint GAP_L   = (longint'(MIN_GAP_NS) * 1000) / CLK_PS;
  localparam longint WIN_L   = (longint'(WINDOW_NS) * 1000) / CLK_PS;
  localparam int     GAP_CYC = int'(GAP_L);
  localparam int     WIN_CYC = int'(WIN_L);

  rowthr_strb_t strb;
  logic         hit, hitReady;

  rowthr_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .actValid(actValid),
    .hit(hit), .hitReady(hitReady), .strb(strb),
    .actGrant(actGrant), .actStall(actStall)
  );

  rowthr_table #(
    .ENTRIES(ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .GAP_CYC(GAP_CYC), .ACT_CAP(ACT_CAP)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .reqBank(actBank), .reqRow(actRow),
    .strb(strb), .hit(hit), .hitReady(hitReady)
  );
endmodule

// File: tb/sim_rowthr_gate.sv
`timescale 1ns/1ps
module sim_rowthr_gate;
  localparam int GAP = 10;   // 50 ns at 5 ns clock
  localparam int WIN = 400;  // 2000 ns at 5 ns clock
  localparam int CAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        actValid = 1'b0;
  logic [2:0]  actBank = '0;
  logic [15:0] actRow = '0;
  logic        actGrant, actStall;
  int          checks = 0, failures = 0, edgeNo = 0, stallBad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) edgeNo <= edgeNo + 1;

  rowthr_gate #(
    .CLK_PS(5000), .MIN_GAP_NS(50), .WINDOW_NS(2000), .ACT_CAP(CAP),
    .ENTRIES(4), .BANK_W(3), .ROW_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .actValid(actValid), .actBank(actBank),
    .actRow(actRow), .actGrant(actGrant), .actStall(actStall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Present one request at a negedge; return stall cycles and grant edge.
  task automatic act(input logic [2:0] b, input logic [15:0] r,
                     output int stalls, output int gEdge);
    actValid = 1'b1; actBank = b; actRow = r;
    stalls = 0; gEdge = -1;
    for (int k = 0; k < 2000; k++) begin
      #1;
      if (actGrant) begin
        gEdge = edgeNo + 1;
        if (actStall) stallBad++;
        @(posedge clk);
        @(negedge clk);
        break;
      end
      if (!actStall) stallBad++;
      stalls++;
      @(negedge clk);
    end
    actValid = 1'b0;
  endtask

  task automatic testReset();
    int s, e;
    #1;
    check(actGrant == 0 && actStall == 0, "R1", "outputs in reset", actGrant + actStall, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(actGrant == 0 && actStall == 0, "R1", "idle outputs", actGrant + actStall, 0);
    @(negedge clk);
    act(3'd0, 16'd7, s, e);
    check(s == 0, "R1", "first request stalls", s, 0);
  endtask

  task automatic testSpacing();
    int s, e0, e1, e2;
    act(3'd2, 16'd40, s, e0);
    act(3'd2, 16'd40, s, e1);
    check(e1 - e0 == GAP, "R2", "same-row grant spacing", e1 - e0, GAP);
    check(stallBad == 0, "R6", "stall flag during wait", stallBad, 0);
    repeat (GAP + 2) @(negedge clk);
    act(3'd2, 16'd40, s, e2);
    check(s == 0, "R2", "stalls after spacing elapsed", s, 0);
  endtask

  task automatic testOtherRows();
    int s, e;
    act(3'd4, 16'd60, s, e);
    act(3'd4, 16'd61, s, e);
    check(s == 0, "R5", "other row same bank", s, 0);
    act(3'd5, 16'd60, s, e);
    check(s == 0, "R5", "same row other bank", s, 0);
    #1;
    check(actGrant == 0 && actStall == 0, "R6", "no request no flags", actGrant + actStall, 0);
  endtask

  task automatic testCap();
    int s, e0, e1, e2, e3;
    do @(negedge clk); while (edgeNo % WIN != 0);
    act(3'd1, 16'd500, s, e0);
    act(3'd1, 16'd500, s, e1);
    act(3'd1, 16'd500, s, e2);
    check(e2 - e0 == 2 * GAP, "R3", "grants below cap spaced", e2 - e0, 2 * GAP);
    stallBad = 0;
    act(3'd1, 16'd500, s, e3);
    check(e3 - e0 == WIN, "R3", "capped row held to window end", e3 - e0, WIN);
    check(e3 % WIN == 1, "R4", "grant right after boundary", e3 % WIN, 1);
    check(stallBad == 0, "R6", "stall flag while capped", stallBad, 0);
  endtask

  task automatic testLru();
    int s, e, e102, eB;
    act(3'd6, 16'd100, s, e);
    act(3'd6, 16'd101, s, e);
    act(3'd6, 16'd102, s, e102);
    act(3'd6, 16'd103, s, e);
    act(3'd6, 16'd104, s, e);
    check(s == 0, "R7", "fifth row allocated", s, 0);
    act(3'd6, 16'd100, s, e);
    check(s == 0, "R7", "evicted row granted at once", s, 0);
    act(3'd6, 16'd102, s, eB);
    check(eB - e102 == GAP, "R7", "tracked row keeps spacing", eB - e102, GAP);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testSpacing();
    testOtherRows();
    testCap();
    testLru();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule